// File: doc/BRIEF.md
# Dual-Select Asynchronous Static Memory, 256 x 4

This block is a small clock-free static memory of 256 words, each 4 bits wide, with a data-in bus and a data-out bus kept apart. It is selected by two chip-select pins of opposite polarity, so several copies can share an address bus and be told apart by decode logic that drives the pins directly. A write-enable pin, active low, chooses between storing and reading. An output-enable pin, active low, gates the read data onto the output.

High impedance is not modelled with internal tri-states. The output is a 4-bit data bus plus one drive-enable flag shared by all bits. When the flag is low the data bus reads zero, and an enclosing pad or bus mux decides what to do with it. A read is purely combinational from address and control to output. A write takes the data present when the write strobe ends. The strobe is the interval during which the part is selected and write enable is low. A word written this way is visible on the outputs as soon as the strobe ends, with no clock and no refresh. There is no streaming interface: every pin is a plain level.

Top module: `sram_dualsel_256x4`

## Requirements
- R1: The memory holds 256 words of 4 bits addressed by `addr[7:0]`. A word written at one address is read back unchanged, and writing one address leaves every other address as it was.
- R2: The part is selected only when `sel_lo_n` is 0 and `sel_hi` is 1. With any other pair of values, `dout_en` is 0 and `dout` is 4'h0.
- R3: A write happens when the part is selected and `wr_n` is 0. The value stored is the one on `din` at the moment that condition ends, whether it ends by `wr_n` rising or by a chip select going inactive.
- R4: With the part selected, `wr_n` at 1 and `rd_en_n` at 0, `dout_en` is 1 and `dout` equals the stored word at `addr`, bit for bit and not inverted.
- R5: With the part selected, `wr_n` at 1 and `rd_en_n` at 1, `dout_en` is 0.
- R6: While `wr_n` is 0, `dout_en` is 0 for either value of `rd_en_n` and either value of the selects.
- R7: When a write ends and the address is held, the newly written word appears on `dout` as soon as the read conditions of R4 hold, with no intervening clock.
- R8: A read has no clock. Changing `addr` while the read conditions hold changes `dout` to the word at the new address without any edge.
- R9: `dout_en` is a single flag covering all 4 data bits. Whenever it is 0, `dout` is 4'h0.
- R10: Holding `wr_n` at 0 while the part is not selected stores nothing, and the addressed word keeps its earlier value.
- R11: If `din` changes while the write strobe is active, only the last value before the strobe ends is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| sel_lo_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Output enable, active low |
| dout | output | 4 | Read data, 4'h0 when not driven |
| dout_en | output | 1 | 1 when `dout` is being driven |

## Verification
A wrong word in the storage shows up on `dout` on the very next read of that address. There is no delay, because the read path has no register. A fault in the select or mode decode shows at once on `dout_en` for the offending combination of the four control pins. For that reason every one of the sixteen combinations is applied and checked. A write that is captured at the wrong moment, or by a strobe that should not exist, only appears when the address is read later. The bench therefore reads back after every write scenario before it moves on.

// File: rtl/sram_dualsel_pkg.sv
package sram_dualsel_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_QUIET = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } mem_mode_e;

endpackage

// File: rtl/sram_dualsel_decode.sv
module sram_dualsel_decode
  import sram_dualsel_pkg::*;
(
  input  logic      sel_lo_n,
  input  logic      sel_hi,
  input  logic      wr_n,
  input  logic      rd_en_n,
  output mem_mode_e mode,
  output logic      wr_strobe_n
);

  logic chosen;

  assign chosen = ~sel_lo_n & sel_hi;

  always_comb begin
    if (!chosen)       mode = MODE_IDLE;
    else if (!wr_n)    mode = MODE_WRITE;
    else if (!rd_en_n) mode = MODE_READ;
    else               mode = MODE_QUIET;
  end

  // The strobe is low for the whole write; its rising edge commits the word.
  assign wr_strobe_n = (mode != MODE_WRITE);

endmodule

// File: rtl/sram_dualsel_array.sv
module sram_dualsel_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_strobe_n,
  output logic [DATA_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_strobe_n) begin
    cells[addr] <= din;
  end

  assign rd_word = cells[addr];

endmodule

// File: rtl/sram_dualsel_outstage.sv
module sram_dualsel_outstage
  import sram_dualsel_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  mem_mode_e         mode,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  assign dout_en = (mode == MODE_READ);
  assign dout    = dout_en ? rd_word : '0;

endmodule

// File: rtl/sram_dualsel_256x4.sv
module sram_dualsel_256x4
  import sram_dualsel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              sel_lo_n,
  input  logic              sel_hi,
  input  logic              wr_n,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  mem_mode_e         mode;
  logic              wr_strobe_n;
  logic [DATA_W-1:0] rd_word;

  sram_dualsel_decode u_decode (
    .sel_lo_n    (sel_lo_n),
    .sel_hi      (sel_hi),
    .wr_n        (wr_n),
    .rd_en_n     (rd_en_n),
    .mode        (mode),
    .wr_strobe_n (wr_strobe_n)
  );

  sram_dualsel_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .addr        (addr),
    .din         (din),
    .wr_strobe_n (wr_strobe_n),
    .rd_word     (rd_word)
  );

  sram_dualsel_outstage #(
    .DATA_W (DATA_W)
  ) u_out (
    .mode    (mode),
    .rd_word (rd_word),
    .dout    (dout),
    .dout_en (dout_en)
  );

  always_comb begin
    if (sel_lo_n || !sel_hi)
      AST_DESELECT_QUIET: assert (!dout_en); // R2
    if (!wr_n)
      AST_WRITE_QUIET: assert (!dout_en); // R6
    if (!sel_lo_n && sel_hi && wr_n && rd_en_n)
      AST_OE_HIGH_QUIET: assert (!dout_en); // R5
    if (!sel_lo_n && sel_hi && wr_n && !rd_en_n)
      AST_READ_DRIVES: assert (dout_en); // R4
    if (!dout_en)
      AST_OFF_IS_ZERO: assert (dout == '0); // R9
    if (!wr_strobe_n)
      AST_STROBE_MUTES: assert (!dout_en); // R3
  end

endmodule

// File: tb/sim_sram_dualsel_256x4.sv
module sim_sram_dualsel_256x4;

  logic       clk = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] din = '0;
  logic       sel_lo_n = 1'b1;
  logic       sel_hi = 1'b0;
  logic       wr_n = 1'b1;
  logic       rd_en_n = 1'b1;
  logic [3:0] dout;
  logic       dout_en;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  sram_dualsel_256x4 u0 (
    .addr     (addr),
    .din      (din),
    .sel_lo_n (sel_lo_n),
    .sel_hi   (sel_hi),
    .wr_n     (wr_n),
    .rd_en_n  (rd_en_n),
    .dout     (dout),
    .dout_en  (dout_en)
  );

  function automatic logic [3:0] pat(input int a, input int k);
    return 4'((a * 5 + (a >> 3) + k) & 15);
  endfunction

  task automatic chk(input string req, input logic [4:0] exp);
    #2;
    total++;
    if ({dout_en, dout} !== exp) begin
      bad++;
      $display("FAIL %s: got en/dout=%h expected %h", req, {dout_en, dout}, exp);
    end
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; din = d; sel_lo_n = 1'b0; sel_hi = 1'b1; rd_en_n = 1'b0; wr_n = 1'b0;
    #2;
    @(negedge clk);
    wr_n = 1'b1;
    #1;
  endtask

  task automatic rd_word(input logic [7:0] a, input logic [3:0] exp, input string req);
    @(negedge clk);
    addr = a; sel_lo_n = 1'b0; sel_hi = 1'b1; wr_n = 1'b1; rd_en_n = 1'b0;
    chk(req, {1'b1, exp});
  endtask

  initial begin
    // R2: reset state, deselected
    #3;
    chk("R2 idle at start", 5'h00);

    // R1: fill every word, read all back in reverse order
    for (int a = 0; a < 256; a++) wr_word(8'(a), pat(a, 3));
    for (int a = 255; a >= 0; a--) rd_word(8'(a), pat(a, 3), "R1 sweep k=3");
    // R1/R4: second pattern, ascending reads
    for (int a = 0; a < 256; a++) wr_word(8'(a), ~pat(a, 11));
    for (int a = 0; a < 256; a++) rd_word(8'(a), ~pat(a, 11), "R4 sweep k=11");

    // R1: single-word write leaves neighbours unchanged
    wr_word(8'h80, 4'hF);
    rd_word(8'h7F, ~pat(127, 11), "R1 neighbour below");
    rd_word(8'h81, ~pat(129, 11), "R1 neighbour above");
    rd_word(8'h80, 4'hF, "R1 target");

    // R6: outputs muted during write, for both output-enable values
    @(negedge clk);
    addr = 8'h33; din = 4'h5; sel_lo_n = 1'b0; sel_hi = 1'b1; rd_en_n = 1'b0; wr_n = 1'b0;
    chk("R6 write oe low", 5'h00);
    rd_en_n = 1'b1;
    chk("R6 write oe high", 5'h00);
    rd_en_n = 1'b0;
    // R11: data changes inside the strobe; last value is kept
    din = 4'hA;
    #2;
    // R7: new data visible the moment the strobe ends
    wr_n = 1'b1;
    chk("R7 R11 immediate after write", 5'h1A);

    // R3: write ended by the active-high select falling
    @(negedge clk);
    addr = 8'h44; din = 4'h3; sel_lo_n = 1'b0; sel_hi = 1'b1; wr_n = 1'b0;
    #2;
    sel_hi = 1'b0;
    #2;
    wr_n = 1'b1; din = 4'hC;
    rd_word(8'h44, 4'h3, "R3 end by select");

    // R3: write ended by the active-low select rising
    @(negedge clk);
    addr = 8'h45; din = 4'h6; sel_lo_n = 1'b0; sel_hi = 1'b1; wr_n = 1'b0;
    #2;
    sel_lo_n = 1'b1;
    #2;
    wr_n = 1'b1; din = 4'h0;
    rd_word(8'h45, 4'h6, "R3 end by active-low select");

    // R8: address change with no clock edge
    @(negedge clk);
    addr = 8'h80;
    chk("R8 addr step a", 5'h1F);
    addr = 8'h44;
    chk("R8 addr step b", 5'h13);

    // R2 R4 R5 R6 R9: every control combination, write data equals stored value
    wr_word(8'h5A, 4'h9);
    for (int i = 0; i < 16; i++) begin
      logic [3:0] c;
      logic       en;
      c = 4'(i);
      @(negedge clk);
      addr = 8'h5A; din = 4'h9;
      sel_lo_n = c[3]; sel_hi = c[2]; wr_n = c[1]; rd_en_n = c[0];
      en = !c[3] && c[2] && c[1] && !c[0];
      chk("R2 R4 R5 R6 R9 mode table", en ? 5'h19 : 5'h00);
    end
    @(negedge clk);
    wr_n = 1'b1;

    // R10: write enable low while deselected stores nothing
    @(negedge clk);
    addr = 8'h5A; din = 4'h6; sel_lo_n = 1'b1; sel_hi = 1'b1; wr_n = 1'b0;
    #2;
    sel_hi = 1'b0;
    #2;
    sel_lo_n = 1'b0;
    #2;
    wr_n = 1'b1;
    #2;
    rd_word(8'h5A, 4'h9, "R10 deselected write ignored");

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule